// File: doc/BRIEF.md
# Word-Aligned Instruction Fetch Unit

This block holds the program counter of a single-cycle processor as a 30-bit word index and presents the matching 32-bit byte address to the instruction memory, whose two low bits are always zero. On every rising clock edge it loads one of three next values:
- the following word;
- a PC-relative target, when a conditional branch resolves true;
- an absolute jump target that stays inside the current 256 MB region.

The branch condition arrives as two control bits from the decoder and the ALU. The offset and the jump target arrive as raw instruction fields.

A single adder with its carry-in tied high forms both the plain increment and the increment plus the sign-extended offset. A multiplexer in front of one adder operand chooses between zero and the offset. The jump path reuses the adder's incremented value to take the upper four address bits and places the 26-bit target field below them.

The reset input is asynchronous and active low. It clears the counter at once. Its release is synchronised to the clock, so the counter starts to advance only after a fixed number of edges.

Top module: `word_fetch_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` and `fetch_addr_o` are zero, and asserting `rst_n` clears them without waiting for a clock edge.
- R2: `fetch_addr_o[31:2]` always equals `pc_o[29:0]`, and `fetch_addr_o[1:0]` is always `2'b00`.
- R3: When `jump_i` is 0 and `branch_i & zero_i` is 0, the next rising edge loads `pc_o + 1`. This covers the case of `branch_i` alone at 1 and the case of `zero_i` alone at 1.
- R4: When `branch_i` and `zero_i` are both 1 and `jump_i` is 0, the next edge loads `pc_o + 1 + S`. S is `imm_i` widened to 30 bits by copying `imm_i[15]` into bits 29..16, so 0x8000 gives -32768 and 0xFFFF gives -1.
- R5: When `jump_i` is 1, the next edge loads `{inc[29:26], target_i[25:0]}`, where `inc = pc_o + 1`. The region bits therefore come from the incremented counter, even when the increment carries into bit 26.
- R6: When `jump_i` is 1 and `branch_i` and `zero_i` are also 1, the jump result of R5 is loaded and the branch offset is ignored.
- R7: The counter is 30 bits wide and wraps modulo 2^30. Incrementing 0x3FFFFFFF gives 0, and a negative offset applied at 0 gives a high address.
- R8: After `rst_n` rises, the counter stays at zero through the next two rising edges and first advances on the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| branch_i | input | 1 | Current instruction is a conditional branch |
| zero_i | input | 1 | Branch comparison found equal operands |
| jump_i | input | 1 | Current instruction is an absolute jump |
| imm_i | input | 16 | Signed word offset of a branch |
| target_i | input | 26 | Word target of a jump within the current region |
| fetch_addr_o | output | 32 | Byte address sent to instruction memory |
| pc_o | output | 30 | Current word program counter |

## Verification
The bench walks a chain of steps in which each expected counter value follows from the previous one. This chain covers the extreme positive and negative offsets, a branch to itself, and a jump taken from the last word of a region. A design that took the region bits from the current counter instead of the incremented one would stay in the old region on that last jump. A design that sign-extended from the wrong bit, or that gave a taken branch priority over a jump, would leave the chain at once.

The bench also clears the counter in the middle of a cycle and counts the edges before the counter advances again. It then wraps the counter in both directions, which exposes a counter narrower than 30 bits or an adder that misses its carry-in.

// File: rtl/wfu_pkg.sv
package wfu_pkg;

  // Source of the next program counter value
  typedef enum logic [1:0] {
    NXT_SEQ    = 2'd0,
    NXT_BRANCH = 2'd1,
    NXT_JUMP   = 2'd2
  } nxt_src_e;

endpackage

// File: rtl/wfu_rst_sync.sv
module wfu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] stg_q;
  logic [LAST:0] stg_d;

  // Shift a one in from the bottom once reset is released
  generate
    if (STAGES > 1) begin : g_multi
      always_comb stg_d = {stg_q[LAST-1:0], 1'b1};
    end else begin : g_single
      always_comb stg_d = 1'b1;
    end
  endgenerate

  // Assertion is immediate; release follows the clock
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign rst_sync_n = stg_q[LAST];

endmodule

// File: rtl/wfu_offset_adder.sv
module wfu_offset_adder #(
  parameter int PC_W  = 30,
  parameter int IMM_W = 16
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             add_off_i,
  output logic [PC_W-1:0]  sum_o
);

  localparam int EXT_W = PC_W - IMM_W;

  logic [PC_W-1:0] sext_off;
  logic [PC_W-1:0] opnd_b;
  logic [PC_W-1:0] carry_in;

  // Widen the offset by copying its top bit
  assign sext_off = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

  // One operand is either zero or the widened offset
  always_comb begin
    if (add_off_i) begin
      opnd_b = sext_off;
    end else begin
      opnd_b = '0;
    end
  end

  // Carry-in tied high gives the +1 in both cases
  assign carry_in = {{(PC_W-1){1'b0}}, 1'b1};
  assign sum_o    = pc_i + opnd_b + carry_in;

endmodule

// File: rtl/wfu_jump_sel.sv
module wfu_jump_sel #(
  parameter int PC_W  = 30,
  parameter int TGT_W = 26
) (
  input  logic [PC_W-1:0]  sum_i,
  input  logic [TGT_W-1:0] target_i,
  input  logic             jump_i,
  output logic [PC_W-1:0]  next_o
);

  localparam int REG_W = PC_W - TGT_W;

  logic [REG_W-1:0] region;

  // Region bits taken from the incremented counter
  assign region = sum_i[PC_W-1:TGT_W];

  always_comb begin
    if (jump_i) begin
      next_o = {region, target_i};
    end else begin
      next_o = sum_i;
    end
  end

endmodule

// File: rtl/wfu_pc_reg.sv
module wfu_pc_reg #(
  parameter int PC_W = 30
) (
  input  logic            clk,
  input  logic            rst_sync_n,
  input  logic [PC_W-1:0] next_i,
  output logic [PC_W-1:0] pc_o
);

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= next_i;
    end
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/word_fetch_unit.sv
module word_fetch_unit
  import wfu_pkg::*;
#(
  parameter int PC_W        = 30,
  parameter int IMM_W       = 16,
  parameter int TGT_W       = 26,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               branch_i,
  input  logic               zero_i,
  input  logic               jump_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [TGT_W-1:0]   target_i,
  output logic [PC_W+1:0]    fetch_addr_o,
  output logic [PC_W-1:0]    pc_o
);

  localparam int EXT_W = PC_W - IMM_W;

  logic            rst_sync_n;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] sum;
  logic [PC_W-1:0] pc_next;
  nxt_src_e        src;

  // Select the next-PC source; the jump outranks a taken branch
  always_comb begin
    if (jump_i) begin
      src = NXT_JUMP;
    end else if (branch_i && zero_i) begin
      src = NXT_BRANCH;
    end else begin
      src = NXT_SEQ;
    end
  end

  wfu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wfu_offset_adder #(.PC_W(PC_W), .IMM_W(IMM_W)) u_adder (
    .pc_i      (pc_q),
    .imm_i     (imm_i),
    .add_off_i (src == NXT_BRANCH),
    .sum_o     (sum)
  );

  wfu_jump_sel #(.PC_W(PC_W), .TGT_W(TGT_W)) u_jump_sel (
    .sum_i    (sum),
    .target_i (target_i),
    .jump_i   (src == NXT_JUMP),
    .next_o   (pc_next)
  );

  wfu_pc_reg #(.PC_W(PC_W)) u_pc_reg (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .next_i     (pc_next),
    .pc_o       (pc_q)
  );

  assign pc_o         = pc_q;
  assign fetch_addr_o = {pc_q, 2'b00};

  // Reference terms, formed apart from the datapath, for the checks below
  logic [PC_W-1:0] chk_incr;
  logic [PC_W-1:0] chk_sext;
  assign chk_incr = pc_q + PC_W'(1);
  assign chk_sext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!jump_i && !(branch_i && zero_i)) |=> (pc_q == $past(chk_incr))); // R3

  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (branch_i && zero_i && !jump_i) |=> (pc_q == $past(chk_incr + chk_sext))); // R4

  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_sync_n)
    jump_i |=> (pc_q[PC_W-1:TGT_W] == $past(chk_incr[PC_W-1:TGT_W]))); // R5

  AST_JUMP_OVER_BRANCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (jump_i && branch_i && zero_i) |=> (pc_q[TGT_W-1:0] == $past(target_i))); // R6

endmodule

// File: tb/word_fetch_unit_tb.sv
module word_fetch_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 15;

  logic        clk;
  logic        rst_n;
  logic        branch_i;
  logic        zero_i;
  logic        jump_i;
  logic [15:0] imm_i;
  logic [25:0] target_i;
  logic [31:0] fetch_addr_o;
  logic [29:0] pc_o;
  logic [31:0] instr;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // Fields: {branch, zero, jump, imm[15:0], target[25:0], expected pc[29:0]}
  localparam logic [74:0] VEC [0:NVEC-1] = '{
    {1'b0, 1'b0, 1'b0, 16'h0000, 26'h0000000, 30'h00000001}, // R3 plain
    {1'b1, 1'b0, 1'b0, 16'h0010, 26'h0000000, 30'h00000002}, // R3 branch only
    {1'b0, 1'b1, 1'b0, 16'h0010, 26'h0000000, 30'h00000003}, // R3 zero only
    {1'b1, 1'b1, 1'b0, 16'h0010, 26'h0000000, 30'h00000014}, // R4 forward
    {1'b1, 1'b1, 1'b0, 16'hFFFB, 26'h0000000, 30'h00000010}, // R4 backward
    {1'b0, 1'b0, 1'b1, 16'h0000, 26'h0ABCDEF, 30'h00ABCDEF}, // R5
    {1'b1, 1'b1, 1'b1, 16'h0100, 26'h0000040, 30'h00000040}, // R6
    {1'b1, 1'b1, 1'b0, 16'h7FFF, 26'h0000000, 30'h00008040}, // R4 max
    {1'b1, 1'b1, 1'b0, 16'h8000, 26'h0000000, 30'h00000041}, // R4 min
    {1'b0, 1'b0, 1'b1, 16'h0000, 26'h3FFFFFF, 30'h03FFFFFF}, // R5
    {1'b0, 1'b0, 1'b0, 16'h0000, 26'h0000000, 30'h04000000}, // R3 carry
    {1'b0, 1'b0, 1'b1, 16'h0000, 26'h0000123, 30'h04000123}, // R5 region 1
    {1'b0, 1'b0, 1'b1, 16'h0000, 26'h3FFFFFF, 30'h07FFFFFF}, // R5
    {1'b0, 1'b0, 1'b1, 16'h0000, 26'h0000007, 30'h08000007}, // R5 from last word
    {1'b1, 1'b1, 1'b0, 16'hFFFF, 26'h0000000, 30'h08000007}  // R4 self
  };

  function automatic logic [31:0] word_at(input int idx);
    return 32'hA500_0000 ^ (idx * 32'h0001_0203);
  endfunction

  // Combinational-read instruction memory
  logic [31:0] imem [0:63];
  initial begin
    for (int i = 0; i < 64; i++) imem[i] = word_at(i);
  end
  assign instr = imem[fetch_addr_o[7:2]];

  word_fetch_unit u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .branch_i     (branch_i),
    .zero_i       (zero_i),
    .jump_i       (jump_i),
    .imm_i        (imm_i),
    .target_i     (target_i),
    .fetch_addr_o (fetch_addr_o),
    .pc_o         (pc_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_pc(input string req, input logic [29:0] exp);
    checks++;
    if (pc_o !== exp) begin
      failures++;
      $display("FAIL %s pc_o act=%h exp=%h", req, pc_o, exp);
    end
    checks++;
    if (fetch_addr_o !== {exp, 2'b00}) begin
      failures++;
      $display("FAIL R2 fetch_addr_o act=%h exp=%h", fetch_addr_o, {exp, 2'b00});
    end
    checks++;
    if (instr !== word_at(int'(exp[5:0]))) begin
      failures++;
      $display("FAIL R2 instr act=%h exp=%h", instr, word_at(int'(exp[5:0])));
    end
  endtask

  task automatic drive(input logic b, input logic z, input logic j,
                       input logic [15:0] im, input logic [25:0] tg);
    branch_i = b;
    zero_i   = z;
    jump_i   = j;
    imm_i    = im;
    target_i = tg;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 16'h0, 26'h0);
    repeat (3) @(negedge clk);
    check_pc("R1", 30'h0);

    // Release and count edges before the first advance
    rst_n = 1'b1;
    @(negedge clk);
    check_pc("R8", 30'h0);
    @(negedge clk);
    check_pc("R8", 30'h0);

    for (int k = 0; k < NVEC; k++) begin
      drive(VEC[k][74], VEC[k][73], VEC[k][72], VEC[k][71:56], VEC[k][55:30]);
      @(negedge clk);
      check_pc($sformatf("R3-R6 step %0d", k), VEC[k][29:0]);
    end

    // Mid-cycle reset clears the counter without a clock edge
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check_pc("R1", 30'h0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 1'b1, 1'b0, 16'hFFFE, 26'h0);
    @(negedge clk);
    check_pc("R8", 30'h0);
    @(negedge clk);
    check_pc("R8", 30'h0);
    @(negedge clk);
    check_pc("R7", 30'h3FFFFFFF);
    drive(1'b0, 1'b0, 1'b0, 16'h0, 26'h0);
    @(negedge clk);
    check_pc("R7", 30'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule